// File: doc/BRIEF.md
# Pulse Wave Audio Channel

This block produces one square-wave voice for a sound generator. A timer counts down from an 11-bit period and advances an eight-step sequencer. One of four duty patterns turns the current step into a high or low level. The level is then scaled by a volume that is either fixed or decays over time. A length counter and a pitch sweep unit can silence the voice or bend its pitch.

The block runs on the processor clock. Two strobes from an external frame sequencer pace the slower units. The quarter-frame strobe clocks the envelope. The half-frame strobe clocks the length counter and the sweep unit. Software programs the channel through four byte-wide registers, each written as a single transfer. The output is a 4-bit sample that changes on every clock and is taken by a mixer outside this block.

The register write port is a valid-only stream. A transfer takes place in every cycle in which `wr_en` is high. The port has no ready signal, because the block accepts one write in every cycle and never applies back-pressure. The strobes and the sample output are plain level signals.

Top module: `pulse_channel`

## Requirements
- R1: While reset is held and after it is released, every counter, register and flag is zero, so `sample` is 0.
- R2: Register selects are 0 = control, 1 = sweep, 2 = period low byte, 3 = period high/length. Control bits [7:6] pick the duty code. Codes 0, 1, 2 and 3 drive the output high for the first 1, 2, 4 and 6 of the eight steps (steps numbered 0..7). The step advances once every 2*(P+1) clocks for a period P.
- R3: A write to select 3 does four things: it places bits [2:0] in period bits [10:8], loads the length counter with 2*N+2 where N is bits [7:3], sets the step to 0, and marks the envelope for a restart. A write to select 2 replaces period bits [7:0].
- R4: When control bit 4 is set, the volume is control bits [3:0]. The sample is either 0 or exactly that volume.
- R5: When control bit 4 is clear, the volume is the decay level. The first quarter strobe after a restart sets the decay level to 15 and loads the divider from control bits [3:0]. After that, the level drops by one every (V+1) quarter strobes. At 0 it reloads to 15 if control bit 5 is set, and holds at 0 otherwise. The decay level changes only on quarter strobes.
- R6: On a half strobe the length counter decrements if it is nonzero and control bit 5 is clear. It changes at no other time except a load. A zero count forces `sample` to 0.
- R7: Sweep bits are: bit 7 enable, [6:4] divider period D, bit 3 negate, [2:0] shift S. The target period is P plus or minus (P >> S). On a half strobe, the period takes the target if four conditions all hold: the divider is 0, the sweep is enabled, S is not 0, and the channel is not muted. On that same strobe, the divider reloads to D if it was 0 or a reload was pending; otherwise it decrements. A write to select 1 makes a reload pending.
- R8: `sample` is forced to 0 while the period is below 8. It is also forced to 0 when negate is clear and the target exceeds 0x7FF.
- R9: With the default `ONES_NEG` = 1, a negated target also subtracts one more (ones' complement style). With `ONES_NEG` = 0 it does not.
- R10: When a register write and a strobe fall in the same cycle, the write wins. A period write discards that cycle's sweep update. A select-3 write overrides that cycle's length decrement and envelope step. A select-1 write leaves a reload pending after that cycle's divider update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write transfer valid; always accepted |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| qtr_tick | input | 1 | Quarter-frame strobe, one clock wide |
| half_tick | input | 1 | Half-frame strobe, one clock wide |
| sample | output | 4 | Channel output level |

## Verification
The bound checker tests several rules on every cycle:
- silence whenever the period is short or the length count is zero;
- a nonzero sample always equals the current volume;
- the step returning to 0 after a high-byte write;
- the decay level and the length count staying still outside their strobes;
- the step moving by at most one position per cycle.

Other behaviour only shows up through the bench's scenarios, compared cycle by cycle against a behavioural model. This includes the exact duty shapes and step rate, the decay cadence with and without looping, length expiry, and the sweep climbing until overflow mutes the channel. It also covers the negated sweep with its extra subtraction and the outcome of writes that collide with strobes.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SWEEP = 2'd1,
    SEL_PLO   = 2'd2,
    SEL_PHI   = 2'd3
  } reg_sel_e;

  // number of high steps among the eight for each duty code
  function automatic logic [3:0] duty_highs(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'd6;
    endcase
  endfunction
endpackage

// File: rtl/pulse_seq.sv
module pulse_seq #(
  parameter int PW = 11,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  input  logic          restart,
  output logic [SW-1:0] step
);
  logic          phase;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cnt   <= '0;
      step  <= '0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (cnt == '0) begin
          cnt  <= period;
          step <= step + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (restart) step <= '0;
    end
  end
endmodule

// File: rtl/pulse_env.sv
module pulse_env #(
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qtr,
  input  logic          restart,
  input  logic          loop_en,
  input  logic          const_en,
  input  logic [VW-1:0] vol_in,
  output logic [VW-1:0] level,
  output logic [VW-1:0] decay
);
  localparam logic [VW-1:0] TOP = {VW{1'b1}};
  logic          start;
  logic [VW-1:0] div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start <= 1'b0;
      div   <= '0;
      decay <= '0;
    end else if (restart) begin
      start <= 1'b1;
    end else if (qtr) begin
      if (start) begin
        start <= 1'b0;
        decay <= TOP;
        div   <= vol_in;
      end else if (div == '0) begin
        div <= vol_in;
        if (decay != '0) decay <= decay - 1'b1;
        else if (loop_en) decay <= TOP;
      end else begin
        div <= div - 1'b1;
      end
    end
  end

  assign level = const_en ? vol_in : decay;
endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep #(
  parameter int PW       = 11,
  parameter int DW       = 3,
  parameter int SHW      = 3,
  parameter bit ONES_NEG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           half,
  input  logic           cfg_wr,
  input  logic           en,
  input  logic [DW-1:0]  div_per,
  input  logic           neg,
  input  logic [SHW-1:0] shift,
  input  logic [PW-1:0]  period_in,
  output logic           upd,
  output logic [PW-1:0]  upd_val,
  output logic           mute
);
  localparam logic [PW-1:0] MIN_PER = PW'(8);
  logic [PW:0]   ext, delta, sum, diff, tgt;
  logic [DW-1:0] div;
  logic          reload;

  assign ext   = {1'b0, period_in};
  assign delta = ext >> shift;
  assign sum   = ext + delta;

  generate
    if (ONES_NEG) begin : g_ones
      assign diff = ext - delta - 1'b1;
    end else begin : g_twos
      assign diff = ext - delta;
    end
  endgenerate

  assign tgt     = neg ? diff : sum;
  assign upd_val = tgt[PW-1:0];
  assign mute    = (period_in < MIN_PER) || (!neg && sum[PW]);
  assign upd     = half && (div == '0) && en && (shift != '0) && !mute;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div    <= '0;
      reload <= 1'b0;
    end else begin
      if (half) begin
        if (div == '0 || reload) begin
          div    <= div_per;
          reload <= 1'b0;
        end else begin
          div <= div - 1'b1;
        end
      end
      if (cfg_wr) reload <= 1'b1;
    end
  end
endmodule

// File: rtl/pulse_channel.sv
module pulse_channel
  import pulse_pkg::*;
#(
  parameter int PW       = 11,
  parameter int VW       = 4,
  parameter int LW       = 7,
  parameter bit ONES_NEG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          qtr_tick,
  input  logic          half_tick,
  output logic [VW-1:0] sample
);
  localparam int SW = 3;

  logic [7:0]    ctrl_q, sweep_q;
  logic [PW-1:0] period_q;
  logic [LW-1:0] len_q;
  logic [SW-1:0] step;
  logic [VW-1:0] level, env_decay;
  logic          hi_wr, sw_upd, mute, wave_hi;
  logic [PW-1:0] sw_val;

  assign hi_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_PHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sweep_q  <= '0;
      period_q <= '0;
      len_q    <= '0;
    end else begin
      if (wr_en && reg_sel_e'(wr_sel) == SEL_CTRL)  ctrl_q  <= wr_data;
      if (wr_en && reg_sel_e'(wr_sel) == SEL_SWEEP) sweep_q <= wr_data;
      if (wr_en && reg_sel_e'(wr_sel) == SEL_PLO)
        period_q[7:0] <= wr_data;
      else if (hi_wr)
        period_q[PW-1:8] <= wr_data[PW-9:0];
      else if (sw_upd)
        period_q <= sw_val;
      if (hi_wr)
        len_q <= LW'({wr_data[7:3], 1'b0}) + LW'(2);
      else if (half_tick && !ctrl_q[5] && len_q != '0)
        len_q <= len_q - 1'b1;
    end
  end

  pulse_seq #(.PW(PW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .period(period_q), .restart(hi_wr), .step(step)
  );

  pulse_env #(.VW(VW)) u_env (
    .clk(clk), .rst_n(rst_n), .qtr(qtr_tick), .restart(hi_wr),
    .loop_en(ctrl_q[5]), .const_en(ctrl_q[4]), .vol_in(ctrl_q[VW-1:0]),
    .level(level), .decay(env_decay)
  );

  pulse_sweep #(.PW(PW), .DW(3), .SHW(3), .ONES_NEG(ONES_NEG)) u_sweep (
    .clk(clk), .rst_n(rst_n), .half(half_tick),
    .cfg_wr(wr_en && reg_sel_e'(wr_sel) == SEL_SWEEP),
    .en(sweep_q[7]), .div_per(sweep_q[6:4]), .neg(sweep_q[3]),
    .shift(sweep_q[2:0]), .period_in(period_q),
    .upd(sw_upd), .upd_val(sw_val), .mute(mute)
  );

  assign wave_hi = {1'b0, step} < duty_highs(ctrl_q[7:6]);
  assign sample  = (len_q != '0 && !mute && wave_hi) ? level : '0;
endmodule

// File: rtl/pulse_channel_chk.sv
module pulse_channel_chk #(
  parameter int PW = 11,
  parameter int VW = 4,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          qtr_tick,
  input logic          half_tick,
  input logic [VW-1:0] sample,
  input logic [PW-1:0] period_q,
  input logic [LW-1:0] len_q,
  input logic [2:0]    step,
  input logic [VW-1:0] level,
  input logic [VW-1:0] env_decay
);
  a_r8_short_period_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q < PW'(8)) |-> (sample == '0));

  a_r6_len_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0) |-> (sample == '0));

  a_r4_sample_is_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sample != '0) |-> (sample == level));

  a_r3_hi_write_resets_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> (step == 3'd0));

  a_r5_decay_waits_for_qtr: assert property (@(posedge clk) disable iff (!rst_n)
    !qtr_tick |=> $stable(env_decay));

  a_r6_len_waits_for_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && !(wr_en && wr_sel == 2'd3)) |=> $stable(len_q));

  a_r2_step_moves_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd3) |=>
      (step == $past(step) || step == 3'($past(step) + 3'd1)));
endmodule

bind pulse_channel pulse_channel_chk #(.PW(PW), .VW(VW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .qtr_tick(qtr_tick), .half_tick(half_tick), .sample(sample),
  .period_q(period_q), .len_q(len_q), .step(step), .level(level),
  .env_decay(env_decay)
);

// File: tb/pulse_channel_test.sv
`timescale 1ns/1ps
module pulse_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       qtr_tick = 1'b0;
  logic       half_tick = 1'b0;
  logic [3:0] sample;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .qtr_tick(qtr_tick), .half_tick(half_tick),
    .sample(sample)
  );

  // behavioural reference state
  int m_ctrl, m_sweep, m_per, m_len, m_ph, m_cnt, m_step;
  int m_start, m_ediv, m_decay, m_sdiv, m_srel;

  function automatic int sweep_target(int p, int sw);
    int d;
    d = p >> (sw & 7);
    if ((sw >> 3) & 1) return p - d - 1;
    return p + d;
  endfunction

  function automatic bit muted(int p, int sw);
    return (p < 8) || (((sw >> 3) & 1) == 0 && sweep_target(p, sw) > 2047);
  endfunction

  function automatic int model_sample();
    int highs, vol;
    case ((m_ctrl >> 6) & 3)
      0: highs = 1;
      1: highs = 2;
      2: highs = 4;
      default: highs = 6;
    endcase
    vol = ((m_ctrl >> 4) & 1) ? (m_ctrl & 15) : m_decay;
    if (m_len != 0 && !muted(m_per, m_sweep) && m_step < highs) return vol;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sweep = 0; m_per = 0; m_len = 0; m_ph = 0; m_cnt = 0;
      m_step = 0; m_start = 0; m_ediv = 0; m_decay = 0; m_sdiv = 0; m_srel = 0;
    end else begin
      int d, n_per, n_len, n_sdiv, n_srel, n_cnt, n_step;
      int n_start, n_ediv, n_decay, vol;
      bit hw, supd;
      d = wr_data;
      vol = m_ctrl & 15;
      hw = wr_en && wr_sel == 3;
      supd = half_tick && m_sdiv == 0 && ((m_sweep >> 7) & 1) && (m_sweep & 7) != 0
             && !muted(m_per, m_sweep);
      n_sdiv = m_sdiv; n_srel = m_srel;
      if (half_tick) begin
        if (m_sdiv == 0 || m_srel != 0) begin n_sdiv = (m_sweep >> 4) & 7; n_srel = 0; end
        else n_sdiv = m_sdiv - 1;
      end
      if (wr_en && wr_sel == 1) n_srel = 1;
      n_per = m_per;
      if (wr_en && wr_sel == 2) n_per = (m_per & 'h700) | d;
      else if (hw) n_per = (m_per & 'hFF) | ((d & 7) << 8);
      else if (supd) n_per = sweep_target(m_per, m_sweep) & 'h7FF;
      n_len = m_len;
      if (hw) n_len = (d >> 3) * 2 + 2;
      else if (half_tick && ((m_ctrl >> 5) & 1) == 0 && m_len > 0) n_len = m_len - 1;
      n_cnt = m_cnt; n_step = m_step;
      if (m_ph) begin
        if (m_cnt == 0) begin n_cnt = m_per; n_step = (m_step + 1) % 8; end
        else n_cnt = m_cnt - 1;
      end
      if (hw) n_step = 0;
      n_start = m_start; n_ediv = m_ediv; n_decay = m_decay;
      if (hw) n_start = 1;
      else if (qtr_tick) begin
        if (m_start) begin n_start = 0; n_decay = 15; n_ediv = vol; end
        else if (m_ediv == 0) begin
          n_ediv = vol;
          if (m_decay > 0) n_decay = m_decay - 1;
          else if ((m_ctrl >> 5) & 1) n_decay = 15;
        end else n_ediv = m_ediv - 1;
      end
      if (wr_en && wr_sel == 0) m_ctrl = d;
      if (wr_en && wr_sel == 1) m_sweep = d;
      m_per = n_per; m_len = n_len; m_sdiv = n_sdiv; m_srel = n_srel;
      m_cnt = n_cnt; m_step = n_step; m_ph = 1 - m_ph;
      m_start = n_start; m_ediv = n_ediv; m_decay = n_decay;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: sample actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!done) check(cur_req, int'(sample), model_sample());
  end

  task automatic cyc(bit q, bit h, bit we, int sel, int d);
    @(negedge clk);
    qtr_tick = q; half_tick = h; wr_en = we;
    wr_sel = 2'(sel); wr_data = 8'(d);
  endtask

  task automatic wr(int sel, int d);
    cyc(1'b0, 1'b0, 1'b1, sel, d);
  endtask

  task automatic run(int n, int qp, int hp);
    for (int i = 1; i <= n; i++)
      cyc(qp > 0 && i % qp == 0, hp > 0 && i % hp == 0, 1'b0, 0, 0);
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #2 check("R1", int'(sample), 0);
    rst_n = 1'b1;
    run(4, 0, 0);
    check("R1", int'(sample), 0);

    // R2 duty shapes at constant volume 9, length halted
    cur_req = "R2";
    for (int dc = 0; dc < 4; dc++) begin
      wr(0, (dc << 6) | 'h30 | 9);
      wr(2, 20);
      wr(3, (10 << 3) | 0);
      run(360, 0, 7);
    end
    wr(2, 9);
    run(200, 0, 0);

    // R3 high-byte write mid-period, restarts step
    cur_req = "R3";
    wr(0, 'h80 | 'h10 | 12);
    wr(3, (3 << 3) | 1);
    run(50, 0, 0);
    wr(3, (3 << 3) | 0);
    run(50, 0, 0);

    // R4 constant volume
    cur_req = "R4";
    wr(0, 'hB0 | 5);
    run(80, 5, 0);

    // R5 decaying envelope, looping then holding
    cur_req = "R5";
    wr(0, 'hA0 | 1);
    wr(2, 12);
    wr(3, (20 << 3));
    run(300, 3, 0);
    wr(0, 'h80 | 0);
    wr(3, (20 << 3));
    run(200, 2, 0);
    check("R5", int'(sample), 0);

    // R6 length expiry
    cur_req = "R6";
    wr(0, 'h90 | 7);
    wr(3, (2 << 3));
    run(60, 0, 5);
    check("R6", int'(sample), 0);

    // R7 upward sweep until overflow mute
    cur_req = "R7";
    wr(0, 'hB0 | 11);
    wr(2, 100);
    wr(3, (31 << 3));
    wr(1, 'h80 | (1 << 4) | 1);
    run(600, 0, 4);
    cur_req = "R8";
    check("R8", int'(sample), 0);

    // R9 negated sweep with extra subtraction
    cur_req = "R9";
    wr(2, 300 & 'hFF);
    wr(3, (31 << 3) | (300 >> 8));
    wr(1, 'h80 | (0 << 4) | 'h8 | 2);
    run(400, 0, 6);

    // R8 short period stays silent
    cur_req = "R8";
    wr(1, 0);
    wr(2, 5);
    wr(3, (31 << 3));
    run(40, 0, 0);
    check("R8", int'(sample), 0);

    // R10 writes colliding with strobes
    cur_req = "R10";
    wr(0, 'h90 | 6);
    wr(2, 40);
    wr(1, 'h80 | (2 << 4) | 1);
    cyc(1'b1, 1'b1, 1'b1, 3, (4 << 3));
    cyc(1'b0, 1'b1, 1'b1, 1, 'h80 | (1 << 4) | 2);
    cyc(1'b0, 1'b1, 1'b1, 2, 60);
    run(300, 3, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule